// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers single-cycle event pulses from every channel of a multi-channel DMA engine and keeps them in packed status words. Channels are arranged in groups. Each group owns one enable word and one status word, and every channel in the group has a fixed-width field inside those words. Each field carries seven event kinds: two completion kinds and five error kinds. One combined interrupt line goes high while any enabled status bit is pending.

Software uses a small valid/write/address/data port. It writes an enable word to choose the events that may raise the interrupt. It reads a status word to see what is pending, and it acknowledges pending events by writing ones back to the status word. To change one channel's enables, software reads the enable word, replaces only that channel's field, and writes the word back. The fields of the other channels are then unchanged.

A status bit records its event whether or not the event is enabled. The enable word only masks the interrupt line.

Top module: `dma_irq_collector`

## Requirements
- R1: After reset, every enable word and every status word reads zero, `irq` is low and `bus_rvalid` is low.
- R2: Channel c belongs to group c/4, and its field occupies bits [(c%4)*8+7 : (c%4)*8] of that group's words. Address 2*g selects the enable word of group g. Address 2*g+1 selects the status word of group g.
- R3: Event input bit c*7+k is the event of kind k for channel c. The kinds are: k=0 one descriptor done, k=1 whole chain done, k=2 descriptor ID mismatch, k=3 address error, k=4 read bus error, k=5 narrow-bus write error, k=6 wide-bus write error. A pulse on that input sets status bit k of the channel's field at the next clock edge, and the bit stays set until it is cleared.
- R4: A status bit is set by its event even while the matching enable bit is zero.
- R5: Writing a status word clears every bit written as 1. Bits written as 0 are left unchanged.
- R6: If an event and a write-one-to-clear of the same status bit occur in the same cycle, the bit stays set.
- R7: A write to an enable word replaces that whole word. Bit 7 of each channel field is reserved: it is never stored and always reads 0. The words of other groups are not affected.
- R8: A write to a status word never changes any enable word. A write to an enable word never changes any status word.
- R9: `irq` is high in the cycle after some status bit is set while its enable bit is set. It is low in the cycle after no such bit exists.
- R10: A read request (`bus_valid` high, `bus_write` low) returns the addressed word on `bus_rdata`, with `bus_rvalid` high for exactly the next cycle. A write request never raises `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 56 | Event pulses, 7 per channel, channel-major |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: group index times 2, plus 1 for status |
| bus_wdata | input | 32 | Write data (enable value or ones-to-clear mask) |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | One-cycle strobe marking valid read data |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The assertions assume that the event inputs and the bus inputs are held low while reset is active. Each checks state only from the first cycle after reset is released. They also assume that every request lasts a single cycle. The bench drives all inputs on the falling edge and holds each request or event pulse for exactly one cycle. It keeps every input at zero during reset, and it only uses addresses that map to an existing group.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  // Event kind positions inside a channel field
  typedef enum int unsigned {
    EV_ONE_DONE      = 0,
    EV_CHAIN_DONE    = 1,
    EV_ID_ERR        = 2,
    EV_ADDR_ERR      = 3,
    EV_RD_BUS_ERR    = 4,
    EV_WR_NARROW_ERR = 5,
    EV_WR_WIDE_ERR   = 6
  } dma_evt_e;

  localparam int unsigned EVT_KINDS = 7;

  // Word selector carried in address bit 0
  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;

  // Bits that hold state in a packed word (reserved field bits excluded)
  function automatic logic [63:0] live_mask(int cpr, int fw, int ew);
    logic [63:0] m;
    m = '0;
    for (int c = 0; c < cpr; c++) begin
      for (int b = 0; b < ew; b++) begin
        m[c*fw + b] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/dma_irq_group.sv
module dma_irq_group
  import dma_irq_pkg::*;
#(
  parameter int CH_PER_REG = 4,
  parameter int FIELD_W    = 8,
  parameter int EVT_W      = 7,
  localparam int REG_W     = CH_PER_REG * FIELD_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en_we,
  input  logic                        sts_clr,
  input  logic [REG_W-1:0]            wdata,
  input  logic [CH_PER_REG*EVT_W-1:0] evt,
  output logic [REG_W-1:0]            en_q,
  output logic [REG_W-1:0]            sts_q,
  output logic                        hit
);

  localparam logic [63:0]      LIVE64 = live_mask(CH_PER_REG, FIELD_W, EVT_W);
  localparam logic [REG_W-1:0] LIVE   = LIVE64[REG_W-1:0];

  logic [REG_W-1:0] evt_word;
  logic [REG_W-1:0] clr_mask;

  // Spread each channel's event pulses into its field
  for (genvar ch = 0; ch < CH_PER_REG; ch++) begin : g_field
    if (FIELD_W > EVT_W) begin : g_pad
      assign evt_word[ch*FIELD_W +: FIELD_W] =
        {{(FIELD_W-EVT_W){1'b0}}, evt[ch*EVT_W +: EVT_W]};
    end else begin : g_nopad
      assign evt_word[ch*FIELD_W +: FIELD_W] = evt[ch*EVT_W +: FIELD_W];
    end
  end

  assign clr_mask = sts_clr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      if (en_we) begin
        en_q <= wdata & LIVE;
      end
      // new events win over a clear in the same cycle
      sts_q <= (sts_q & ~clr_mask) | evt_word;
    end
  end

  assign hit = |(en_q & sts_q);

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(evt_word) & ~sts_q) == '0)) else $error("event lost"); // R3

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sts_clr)) |-> (($past(sts_q) & ~sts_q) == '0)) else $error("status dropped"); // R5

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en_we)) |-> $stable(en_q)) else $error("enable changed"); // R8

endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux #(
  parameter int NUM_REG = 2,
  parameter int REG_W   = 32,
  parameter int ADDR_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_req,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [NUM_REG*REG_W-1:0] en_words,
  input  logic [NUM_REG*REG_W-1:0] sts_words,
  output logic [REG_W-1:0]         rdata,
  output logic                     rvalid
);

  logic [ADDR_W-1:0] grp;
  logic [REG_W-1:0]  sel_word;

  assign grp = rd_addr >> 1;

  always_comb begin
    sel_word = '0;
    for (int g = 0; g < NUM_REG; g++) begin
      if (int'(grp) == g) begin
        sel_word = rd_addr[0] ? sts_words[g*REG_W +: REG_W]
                              : en_words[g*REG_W +: REG_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) begin
        rdata <= sel_word;
      end
    end
  end

endmodule

// File: rtl/dma_irq_collector.sv
module dma_irq_collector
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int CH_PER_REG = 4,
  parameter int FIELD_W    = 8,
  parameter int EVT_W      = 7,
  parameter int ADDR_W     = $clog2(NUM_CH / CH_PER_REG) + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CH*EVT_W-1:0]       evt_i,
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [CH_PER_REG*FIELD_W-1:0] bus_wdata,
  output logic [CH_PER_REG*FIELD_W-1:0] bus_rdata,
  output logic                          bus_rvalid,
  output logic                          irq
);

  localparam int REG_W   = CH_PER_REG * FIELD_W;
  localparam int NUM_REG = NUM_CH / CH_PER_REG;
  localparam int GRP_EVT = CH_PER_REG * EVT_W;
  localparam logic [63:0]      LIVE64 = live_mask(CH_PER_REG, FIELD_W, EVT_W);
  localparam logic [REG_W-1:0] LIVE   = LIVE64[REG_W-1:0];

  logic [NUM_REG*REG_W-1:0] en_words;
  logic [NUM_REG*REG_W-1:0] sts_words;
  logic [NUM_REG-1:0]       hits;
  logic                     hit_any;
  logic                     wr_req;
  logic                     rd_req;

  assign wr_req = bus_valid & bus_write;
  assign rd_req = bus_valid & ~bus_write;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_grp
    logic en_sel;
    logic sts_sel;
    assign en_sel  = wr_req && (bus_addr == ADDR_W'(2*g + int'(SEL_ENABLE)));
    assign sts_sel = wr_req && (bus_addr == ADDR_W'(2*g + int'(SEL_STATUS)));

    dma_irq_group #(
      .CH_PER_REG (CH_PER_REG),
      .FIELD_W    (FIELD_W),
      .EVT_W      (EVT_W)
    ) u_grp (
      .clk     (clk),
      .rst     (rst),
      .en_we   (en_sel),
      .sts_clr (sts_sel),
      .wdata   (bus_wdata),
      .evt     (evt_i[g*GRP_EVT +: GRP_EVT]),
      .en_q    (en_words[g*REG_W +: REG_W]),
      .sts_q   (sts_words[g*REG_W +: REG_W]),
      .hit     (hits[g])
    );
  end

  dma_irq_rdmux #(
    .NUM_REG (NUM_REG),
    .REG_W   (REG_W),
    .ADDR_W  (ADDR_W)
  ) u_rdmux (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .rd_addr   (bus_addr),
    .en_words  (en_words),
    .sts_words (sts_words),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid)
  );

  assign hit_any = |hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= hit_any;
    end
  end

  AST_RVALID_SRC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && bus_rvalid) |-> $past(bus_valid && !bus_write)) else $error("stray rvalid"); // R10

  AST_RSVD_RD: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> ((bus_rdata & ~LIVE) == '0)) else $error("reserved bit set"); // R7

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(|(en_words & sts_words))) |-> irq) else $error("irq missing"); // R9

  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(|(en_words & sts_words))) |-> !irq) else $error("irq spurious"); // R9

endmodule

// File: tb/dma_irq_collector_bench.sv
module dma_irq_collector_bench;

  localparam int NCH = 8;
  localparam int EW  = 7;
  localparam int AW  = 2;
  localparam logic [31:0] LIVE = 32'h7F7F7F7F;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NCH*EW-1:0] evt_i = '0;
  logic             bus_valid = 1'b0;
  logic             bus_write = 1'b0;
  logic [AW-1:0]    bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             bus_rvalid;
  logic             irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] en_m  [2];
  logic [31:0] sts_m [2];

  always #10 clk = ~clk;

  dma_irq_collector u_dma_irq_collector (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt_i),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq        (irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Event vector bit for channel c, kind k
  function automatic logic [NCH*EW-1:0] ev(int c, int k);
    logic [NCH*EW-1:0] v;
    v = '0;
    v[c*EW + k] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] grp_bits(logic [NCH*EW-1:0] e, int g);
    logic [31:0] w;
    w = '0;
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < EW; k++)
        w[c*8 + k] = e[(g*4 + c)*EW + k];
    return w;
  endfunction

  // Driver: one-cycle request plus events; pushes expected read data
  task automatic drive(logic v, logic w, logic [AW-1:0] a, logic [31:0] d,
                       logic [NCH*EW-1:0] e, string tag);
    int g;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; evt_i = e;
    g = int'(a) >> 1;
    if (v && !w) begin
      exp_q.push_back(a[0] ? sts_m[g] : en_m[g]);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; evt_i = '0;
    for (int gg = 0; gg < 2; gg++) begin
      logic [31:0] clr;
      clr = (v && w && a == AW'(2*gg+1)) ? d : 32'h0;
      sts_m[gg] = (sts_m[gg] & ~clr) | grp_bits(e, gg);
      if (v && w && a == AW'(2*gg)) en_m[gg] = d & LIVE;
    end
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    drive(1'b1, 1'b0, a, 32'h0, '0, tag);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, string tag);
    drive(1'b1, 1'b1, a, d, '0, tag);
  endtask

  task automatic pulse(logic [NCH*EW-1:0] e);
    drive(1'b0, 1'b0, '0, 32'h0, e, "");
  endtask

  task automatic chk_irq(string tag);
    @(negedge clk);
    chk(tag, {31'h0, irq}, {31'h0, |((en_m[0] & sts_m[0]) | (en_m[1] & sts_m[1]))});
  endtask

  // Monitor: pops expected read data when the design returns it
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 actual=rvalid expected=no-rvalid");
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int g = 0; g < 2; g++) begin en_m[g] = '0; sts_m[g] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 rvalid", {31'h0, bus_rvalid}, 32'h0);
    for (int a = 0; a < 4; a++) rd(AW'(a), "R1 reset word");

    // R7: reserved bits dropped, R8: status untouched
    wr(2'd0, 32'hFFFFFFFF, "R7");
    rd(2'd0, "R7 enable readback");
    rd(2'd2, "R7 other group untouched");
    rd(2'd1, "R8 status after enable write");

    // R3/R2: channel 1 ID error -> group 0 bit 10
    pulse(ev(1, 2));
    rd(2'd1, "R3 R2 ch1 id err");
    chk("R2 ch1 field", sts_m[0], 32'h0000_0400);
    chk_irq("R9 irq on enabled");

    // R4: channel 6 one-done into disabled group 1
    pulse(ev(6, 0));
    rd(2'd3, "R4 R2 latched while disabled");

    // R5: zero write has no effect, then ones clear
    wr(2'd1, 32'h0, "R5");
    rd(2'd1, "R5 zero write no effect");
    wr(2'd1, 32'h0000_0400, "R5");
    rd(2'd1, "R5 cleared");
    rd(2'd0, "R8 enable after status write");
    chk_irq("R9 irq low with only disabled pending");

    // R7: read-modify-write of group 1 fields
    wr(2'd2, 32'h0001_0000, "R7");
    chk_irq("R9 irq after enable");
    wr(2'd2, en_m[1] | 32'hFF00_0000, "R7");
    rd(2'd2, "R7 rmw keeps ch6 field");
    rd(2'd3, "R8 status after enable write");

    // R6: event and clear of same bit in one cycle
    pulse(ev(3, 1));
    drive(1'b1, 1'b1, 2'd1, 32'h0200_0000, ev(3, 1), "R6");
    rd(2'd1, "R6 bit stays set");
    wr(2'd1, 32'h0200_0000, "R6");
    rd(2'd1, "R6 cleared afterwards");

    // R3: all kinds on two channels at once
    pulse(ev(0,0)|ev(0,1)|ev(0,2)|ev(0,3)|ev(0,4)|ev(0,5)|ev(0,6)|
          ev(4,0)|ev(4,1)|ev(4,2)|ev(4,3)|ev(4,4)|ev(4,5)|ev(4,6));
    rd(2'd1, "R3 all kinds ch0");
    rd(2'd3, "R3 all kinds ch4");
    chk_irq("R9 irq with many");

    // clear everything
    wr(2'd1, 32'hFFFF_FFFF, "R5");
    wr(2'd3, 32'hFFFF_FFFF, "R5");
    rd(2'd1, "R5 all clear g0");
    rd(2'd3, "R5 all clear g1");
    chk_irq("R9 irq drops");
    repeat (3) @(negedge clk);
    chk("R10 queue drained", exp_q.size(), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule